// File: doc/BRIEF.md
# Slew-Limited Phase Increment Ramp

This block sits in front of a phase accumulator in a direct digital synthesis path and supplies its tuning word. The tuning word is not loaded directly. Software writes a target increment, and the block walks its own 64-bit unsigned fixed-point copy of the increment toward that target once per clock. Each tick the increment may rise by at most a rise step and fall by at most a fall step. The two limits are set separately. The result is an output frequency whose rate of change is bounded in each direction.

At 40 MHz, a 0 to 6000 Hz range at 1 Hz resolution puts one hertz of frequency in the low tens of bits of a 32-bit tuning word. A change of 100 Hz/s then moves the word by a tiny fraction of one of its LSBs per tick. The block therefore keeps the state with 32 extra fractional bits, so the slow ramps need no prescaling. The accumulator receives only the upper bits.

When the remaining distance is no larger than the allowed step, the value lands exactly on the target, so it never passes it. A step limit of zero stops all movement in that direction. A flag reports when the stored value matches the target.

Top module: `slew_ramp`

## Requirements
- R1: A synchronous active-high `rst` sets the internal 64-bit increment to zero and clears `at_target` on the next clock edge.
- R2: While `en` is low the internal increment keeps its value, whatever the target and step inputs do.
- R3: While `en` is high and the target is above the internal value by more than `rise_step`, each clock adds exactly `rise_step` to the internal value.
- R4: While `en` is high and the target is below the internal value by more than `fall_step`, each clock subtracts exactly `fall_step` from the internal value.
- R5: When the distance to the target is less than or equal to the step for that direction, the next internal value equals the target exactly. This holds even when the target is at the full-scale value 2^64-1 or at zero, with no wrap-around.
- R6: A `rise_step` of zero keeps the value from rising, and a `fall_step` of zero keeps it from falling. Movement in the other direction is not affected.
- R7: After each clock, `at_target` is 1 exactly when the updated internal value equals the `target` that was presented on that clock.
- R8: `incr_out` is the top OUT_W bits (bits 63 down to 64-OUT_W) of the internal value; the lower bits are fractional and are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the ramp updates once per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Ramp enable; when low the increment holds |
| target | input | 64 | Target increment, unsigned, 32 fractional bits below the output word |
| rise_step | input | 64 | Largest increase allowed per clock |
| fall_step | input | 64 | Largest decrease allowed per clock |
| incr_out | output | OUT_W (32) | Tuning word for the phase accumulator (upper bits of the internal value) |
| at_target | output | 1 | Internal value equals the target |

## Verification
The delicate case is a direction reversal and a landing in the same cycle. The bench provokes it by moving the target to the other side of the value mid-ramp, at a distance smaller than the opposite step. The block must then turn around and stop exactly on the new target in one clock, and it must raise `at_target` on that same edge. An independent signed-difference model judges the result cycle by cycle. The same model covers a landing at full scale, where an unguarded add would wrap.

// File: rtl/slew_ramp_pkg.sv
package slew_ramp_pkg;
  localparam int unsigned RAMP_W = 64;

  typedef logic [RAMP_W-1:0] ramp_t;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DOWN = 2'b10
  } ramp_dir_e;

  // distance between two unsigned values, never negative
  function automatic ramp_t ramp_gap(input ramp_t a, input ramp_t b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // the step covers what is left, so the move lands on the target
  function automatic logic ramp_lands(input ramp_t gap, input ramp_t step);
    return step >= gap;
  endfunction
endpackage

// File: rtl/slew_gap.sv
module slew_gap
  import slew_ramp_pkg::*;
(
  input  ramp_t     cur_i,
  input  ramp_t     tgt_i,
  output ramp_dir_e dir_o,
  output ramp_t     gap_o
);
  always_comb begin
    if (tgt_i > cur_i)      dir_o = DIR_UP;
    else if (tgt_i < cur_i) dir_o = DIR_DOWN;
    else                    dir_o = DIR_HOLD;
    gap_o = ramp_gap(cur_i, tgt_i);
  end
endmodule

// File: rtl/slew_limit.sv
module slew_limit
  import slew_ramp_pkg::*;
#(
  parameter bit GO_UP = 1'b1
) (
  input  ramp_t cur_i,
  input  ramp_t tgt_i,
  input  ramp_t gap_i,
  input  ramp_t step_i,
  output logic  snap_o,
  output ramp_t land_o
);
  ramp_t moved;

  generate
    if (GO_UP) begin : g_add
      assign moved = cur_i + step_i;
    end else begin : g_sub
      assign moved = cur_i - step_i;
    end
  endgenerate

  // choosing the target on a landing also prevents wrap at either end
  assign snap_o = ramp_lands(gap_i, step_i);
  assign land_o = snap_o ? tgt_i : moved;
endmodule

// File: rtl/slew_ramp.sv
module slew_ramp
  import slew_ramp_pkg::*;
#(
  parameter int unsigned OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [63:0]      target,
  input  logic [63:0]      rise_step,
  input  logic [63:0]      fall_step,
  output logic [OUT_W-1:0] incr_out,
  output logic             at_target
);
  localparam int unsigned TOP_BIT = RAMP_W - 1;
  localparam int unsigned N_DIR   = 2;

  ramp_t     cur_q;
  ramp_t     cur_nxt;
  ramp_t     gap;
  ramp_dir_e dir;
  ramp_t     step_sel [N_DIR];
  ramp_t     land     [N_DIR];
  logic      snap     [N_DIR];
  logic      snap_now;
  logic      at_q;

  assign step_sel[0] = rise_step;
  assign step_sel[1] = fall_step;

  slew_gap u_gap (
    .cur_i (cur_q),
    .tgt_i (target),
    .dir_o (dir),
    .gap_o (gap)
  );

  generate
    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
      slew_limit #(.GO_UP(d == 0)) u_lim (
        .cur_i  (cur_q),
        .tgt_i  (target),
        .gap_i  (gap),
        .step_i (step_sel[d]),
        .snap_o (snap[d]),
        .land_o (land[d])
      );
    end
  endgenerate

  always_comb begin
    cur_nxt  = cur_q;
    snap_now = 1'b0;
    if (en) begin
      unique case (dir)
        DIR_UP: begin
          cur_nxt  = land[0];
          snap_now = snap[0];
        end
        DIR_DOWN: begin
          cur_nxt  = land[1];
          snap_now = snap[1];
        end
        default: begin
          cur_nxt  = cur_q;
          snap_now = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      at_q  <= 1'b0;
    end else begin
      cur_q <= cur_nxt;
      at_q  <= (en && snap_now) || (cur_nxt == target);
    end
  end

  assign incr_out  = cur_q[TOP_BIT -: OUT_W];
  assign at_target = at_q;
endmodule

// File: rtl/slew_ramp_chk.sv
module slew_ramp_chk
  import slew_ramp_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  en,
  input ramp_t target,
  input ramp_t rise_step,
  input ramp_t fall_step,
  input ramp_t cur_q,
  input logic  at_target
);
  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    (seen && $past(rst)) |-> (cur_q == '0 && !at_target));

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst) && !$past(en)) |-> (cur_q == $past(cur_q)));

  // R3
  rise_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst) && $past(en) && $past(cur_q) < $past(target))
    |-> (cur_q >= $past(cur_q) && cur_q <= $past(target)
         && (cur_q - $past(cur_q)) <= $past(rise_step)));

  // R4
  fall_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst) && $past(en) && $past(cur_q) > $past(target))
    |-> (cur_q <= $past(cur_q) && cur_q >= $past(target)
         && ($past(cur_q) - cur_q) <= $past(fall_step)));

  // R6
  rise_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst) && $past(en) && $past(rise_step) == '0
     && $past(cur_q) < $past(target)) |-> (cur_q == $past(cur_q)));

  // R7
  at_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst)) |-> (at_target == (cur_q == $past(target))));
endmodule

bind slew_ramp slew_ramp_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .target    (target),
  .rise_step (rise_step),
  .fall_step (fall_step),
  .cur_q     (cur_q),
  .at_target (at_target)
);

// File: tb/sim_slew_ramp.sv
module sim_slew_ramp;
  localparam int unsigned OUT_W = 32;
  localparam int unsigned W     = 64;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en  = 1'b0;
  logic [W-1:0]     target    = '0;
  logic [W-1:0]     rise_step = '0;
  logic [W-1:0]     fall_step = '0;
  logic [OUT_W-1:0] incr_out;
  logic             at_target;

  always #4 clk = ~clk;

  slew_ramp #(.OUT_W(OUT_W)) u0 (
    .clk(clk), .rst(rst), .en(en), .target(target),
    .rise_step(rise_step), .fall_step(fall_step),
    .incr_out(incr_out), .at_target(at_target)
  );

  typedef struct {
    logic [OUT_W-1:0] inc;
    logic             at;
    string            req;
  } exp_t;

  exp_t         sb[$];
  int           n_cmp = 0;
  int           n_bad = 0;
  logic [W-1:0] m_cur = '0;
  bit           done  = 1'b0;

  // driver: applies one clock of stimulus and queues the model's result
  task automatic drive(input logic r, input logic e, input logic [W-1:0] t,
                       input logic [W-1:0] up, input logic [W-1:0] dn,
                       input string req);
    exp_t x;
    logic signed [W+1:0] diff;
    logic signed [W+1:0] su;
    logic signed [W+1:0] sd;
    logic [W-1:0] nxt;
    @(negedge clk);
    rst = r; en = e; target = t; rise_step = up; fall_step = dn;
    diff = $signed({2'b00, t}) - $signed({2'b00, m_cur});
    su   = $signed({2'b00, up});
    sd   = $signed({2'b00, dn});
    if (r)             nxt = '0;
    else if (!e)       nxt = m_cur;
    else if (diff > 0) nxt = (diff <= su) ? t : m_cur + up;
    else if (diff < 0) nxt = (-diff <= sd) ? t : m_cur - dn;
    else               nxt = m_cur;
    m_cur = nxt;
    x.inc = nxt[W-1 -: OUT_W];
    x.at  = !r && (nxt == t);
    x.req = req;
    @(posedge clk);
    #1 sb.push_back(x);
  endtask

  // monitor: compares each queued result away from the clock edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      n_cmp++;
      if (incr_out !== x.inc || at_target !== x.at) begin
        n_bad++;
        $display("FAIL %s: incr_out=%h at_target=%b expected incr_out=%h at_target=%b",
                 x.req, incr_out, at_target, x.inc, x.at);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    drive(1'b1, 1'b0, 64'h5_0000_0000, '1, '1, "R1");
    drive(1'b1, 1'b1, 64'h5_0000_0000, '1, '1, "R1");
    // R3 R5 R8: rise by 1.5 output LSB per tick, land on 5.0
    for (int i = 0; i < 5; i++)
      drive(1'b0, 1'b1, 64'h5_0000_0000, 64'h1_8000_0000, 64'h1, "R3_R5_R8_R7");
    // R2: enable low, target moves, value holds
    for (int i = 0; i < 3; i++)
      drive(1'b0, 1'b0, 64'h40_0000_0000, '1, '1, "R2");
    // R4: fall by 0.25 per tick toward 2.0
    for (int i = 0; i < 14; i++)
      drive(1'b0, 1'b1, 64'h2_0000_0000, 64'h0, 64'h4000_0000, "R4_R5_R7");
    // R6: zero rise step freezes upward motion
    for (int i = 0; i < 4; i++)
      drive(1'b0, 1'b1, 64'h9_0000_0000, 64'h0, 64'h4000_0000, "R6");
    // R6: falling still works with rise step zero
    for (int i = 0; i < 3; i++)
      drive(1'b0, 1'b1, 64'h1_0000_0000, 64'h0, 64'h2000_0000, "R6_R4");
    // reversal: rising, then target below by less than the fall step
    for (int i = 0; i < 3; i++)
      drive(1'b0, 1'b1, 64'h8_0000_0000, 64'h8000_0000, 64'h1_0000_0000, "R3");
    drive(1'b0, 1'b1, 64'h2_4000_0000, 64'h8000_0000, 64'h1_0000_0000, "R5_R7_reverse");
    drive(1'b0, 1'b1, 64'h2_4000_0000, 64'h8000_0000, 64'h1_0000_0000, "R7_settled");
    // R8: sub-LSB step moves fractional bits only
    for (int i = 0; i < 3; i++)
      drive(1'b0, 1'b1, 64'h3_0000_0000, 64'h1, 64'h1, "R8_fraction");
    // R5: full-scale landing without wrap, then back to zero
    drive(1'b0, 1'b1, '1, 64'hFFFF_0000_0000_0000, 64'h1, "R3_fullscale");
    drive(1'b0, 1'b1, '1, 64'hFFFF_0000_0000_0000, 64'h1, "R5_fullscale");
    drive(1'b0, 1'b1, '1, 64'hFFFF_0000_0000_0000, 64'h1, "R5_no_wrap");
    drive(1'b0, 1'b1, 64'h0, 64'h1, '1, "R5_zero");
    // R1: reset mid-value
    drive(1'b1, 1'b1, 64'h7_0000_0000, '1, '1, "R1_again");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule